// File: doc/BRIEF.md
# Three-Wire Tuning Word Receiver

This block takes a serial control word carried on three wires (an enable level, a shift clock and a data line) and turns it into the settings of a tuning synthesizer. These settings are a four-bit band-switch register, a fifteen-bit divider word and a seven-bit control group. The control group holds the charge-pump current select, three test bits, two reference-ratio select bits and the tuning-output disable. All three wires must already be synchronised to the system clock. The block finds the edges of the enable and shift-clock lines itself, by comparing each wire with its value one cycle earlier.

The word carries no header that names its format. The block counts the bits shifted in while enable is high, and that count selects what is committed. An 18-bit word supplies a 14-bit divider and selects ratio A = 1. A 19-bit word supplies the full 15-bit divider and selects ratio A = 0. A 27-bit word also carries the control group. The band bits are committed in the middle of every word. In a long word the divider is also committed in the middle of the word, and the control group is committed when enable drops. A strap input selects the reset value of ratio bit B, so that both product variants can be built from one netlist.

Top module: `tw_word_receiver`

## Requirements
- R1: A data bit is shifted in only on a falling edge of `sck_i` while `ce_i` is high. The level of `sdat_i` at the rising edge does not matter. Edges on `sck_i` while `ce_i` is low change no output.
- R2: The first four bits of a word go to the band register, with the first bit in `band_o[3]` and the fourth bit in `band_o[0]`. They are committed on the first rising edge of `sck_i` after the fourth bit has been shifted in, while the word is still in progress.
- R3: When `ce_i` falls after exactly 18 bits, `freq_o` becomes {0, bits 5..18}, with bit 5 as the MSB of the 14 loaded bits, and `rsa_o` becomes 1.
- R4: When `ce_i` falls after exactly 19 bits, `freq_o` becomes bits 5..19, with bit 5 in `freq_o[14]`, and `rsa_o` becomes 0.
- R5: In any word of 20 or more bits, `freq_o` takes bits 5..19 on the rising edge of `sck_i` that follows bit 19, before `ce_i` falls.
- R6: When `ce_i` falls after exactly 27 bits, bit 20 is ignored. Bits 21 to 27 load, in that order, into `cp_o`, `test_o[2]`, `test_o[1]`, `test_o[0]`, `rsa_o`, `rsb_o` and `os_o`.
- R7: An 18-bit or 19-bit word leaves `cp_o`, `test_o`, `rsb_o` and `os_o` unchanged.
- R8: A word of fewer than 18 bits leaves `freq_o` and every control output unchanged.
- R9: A word of 20 to 26 bits, or of 28 bits or more, leaves every control output unchanged. It changes `freq_o` only through the R5 load.
- R10: The bit count saturates at 31, so an over-long word commits nothing when `ce_i` falls. The count restarts from zero when `ce_i` rises, so a normal word that follows an over-long one is decoded correctly.
- R11: After reset, `band_o` = 0, `freq_o` = 0, `cp_o` = 1, `test_o` = 3'b001, `rsa_o` = 0, `os_o` = 1, and `rsb_o` equals `rsb_init_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 1 | Word enable, synchronised |
| sck_i | input | 1 | Shift clock, synchronised |
| sdat_i | input | 1 | Serial data, synchronised |
| rsb_init_i | input | 1 | Variant strap: reset value of ratio bit B |
| band_o | output | 4 | Band-switch register |
| freq_o | output | 15 | Divider word |
| cp_o | output | 1 | Charge-pump current select |
| test_o | output | 3 | Test-mode bits |
| rsa_o | output | 1 | Reference ratio select A |
| rsb_o | output | 1 | Reference ratio select B |
| os_o | output | 1 | Tuning output disable |

## Verification
Because the bit count selects the format, a count that is off by one shows up at the next drop of `ce_i`. An 18-bit word then looks like a 19-bit word, or the reverse, so `rsa_o` takes the wrong value and `freq_o` is loaded from a shifted field. A long word then leaves the control outputs stale. An error in the edge detection or the shift register appears earlier, in the middle of the word. The band value committed after bit four, or the divider committed after bit nineteen, carries the wrong bits within a few system cycles of that shift-clock edge. A stimulus that changes the data line while the shift clock is high exposes a design that samples on the wrong edge, because that design then captures the inverted bit.

// File: rtl/tw_pkg.sv
// Shared constants and the control-group type for the three-wire receiver.
// Assumes the word layout: four band bits, fifteen divider bits, one marker
// bit, seven control bits.
package tw_pkg;
    localparam int BAND_W    = 4;
    localparam int FREQ_W    = 15;
    localparam int CTRL_BITS = 7;
    localparam int LEN_SHORT = BAND_W + FREQ_W - 1;     // 18
    localparam int LEN_MID   = BAND_W + FREQ_W;         // 19
    localparam int LEN_LONG  = LEN_MID + 1 + CTRL_BITS; // 27
    localparam int CNT_W     = 5;
    localparam int SR_W      = LEN_LONG;

    typedef struct packed {
        logic       cp;
        logic [2:0] test;
        logic       rsa;
        logic       rsb;
        logic       os;
    } ctrl_t;
endpackage

// File: rtl/tw_edge_detect.sv
// Edge finder for a group of already synchronised level inputs.
// Assumes each input is stable with respect to clk; reports the rise or
// fall in the same cycle the new level first appears.
module tw_edge_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] lvl_q;

    for (genvar g = 0; g < N; g++) begin : g_lane
        // Hold the previous level of this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[g] <= 1'b0;
            else        lvl_q[g] <= lvl_i[g];
        end

        // Compare current and previous level.
        always_comb begin
            rise_o[g] = lvl_i[g] & ~lvl_q[g];
            fall_o[g] = ~lvl_i[g] & lvl_q[g];
        end
    end
endmodule

// File: rtl/tw_shift_count.sv
// Serial capture: shifts one data bit per falling shift-clock edge while
// the enable is high, and counts the bits with saturation.
// Assumes edge strobes come from tw_edge_detect.
module tw_shift_count #(
    parameter int SR_W  = tw_pkg::SR_W,
    parameter int CNT_W = tw_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_lvl_i,
    input  logic             ce_rise_i,
    input  logic             sck_fall_i,
    input  logic             sdat_i,
    output logic [SR_W-1:0]  sr_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic shift_en;

    // A bit is taken only on a falling clock inside an enabled window.
    always_comb shift_en = sck_fall_i & ce_lvl_i;

    // Shift register, newest bit at position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_o <= '0;
        else if (shift_en) sr_o <= {sr_o[SR_W-2:0], sdat_i};
    end

    // Bit counter: restarts on enable rise, stops at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (ce_rise_i)
            cnt_o <= shift_en ? CNT_W'(1) : '0;
        else if (shift_en && cnt_o != CNT_MAX)
            cnt_o <= cnt_o + CNT_W'(1);
    end

    assert_cnt_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !ce_rise_i) |=> cnt_o == CNT_MAX);

    assert_cnt_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rise_i |=> cnt_o <= CNT_W'(1));

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_rise_i && !(sck_fall_i && ce_lvl_i)) |=> $stable(cnt_o) && $stable(sr_o));
endmodule

// File: rtl/tw_commit_regs.sv
// Output registers: decides from the bit count which fields of the shifted
// word to commit, either mid-word on a rising clock or at enable fall.
// Assumes count and shift register come from tw_shift_count.
module tw_commit_regs
    import tw_pkg::*;
#(
    parameter int SR_W  = tw_pkg::SR_W,
    parameter int CNT_W = tw_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsb_init_i,
    input  logic              ce_lvl_i,
    input  logic              ce_fall_i,
    input  logic              sck_rise_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [SR_W-1:0]   sr_i,
    output logic [BAND_W-1:0] band_o,
    output logic [FREQ_W-1:0] freq_o,
    output ctrl_t             ctrl_o
);
    localparam int FREQ_AT = BAND_W + FREQ_W;

    logic band_ld, freq_mid_ld, end_short, end_mid, end_long;

    // Decode the commit events from count and edges.
    always_comb begin
        band_ld     = sck_rise_i & ce_lvl_i & (cnt_i == CNT_W'(BAND_W));
        freq_mid_ld = sck_rise_i & ce_lvl_i & (cnt_i == CNT_W'(FREQ_AT));
        end_short   = ce_fall_i & (cnt_i == CNT_W'(LEN_SHORT));
        end_mid     = ce_fall_i & (cnt_i == CNT_W'(LEN_MID));
        end_long    = ce_fall_i & (cnt_i == CNT_W'(LEN_LONG));
    end

    // Band register: first four bits, committed mid-word.
    always_ff @(posedge clk) begin
        if (!rst_n)       band_o <= '0;
        else if (band_ld) band_o <= sr_i[BAND_W-1:0];
    end

    // Divider word: short and mid words at enable fall, long words mid-word.
    always_ff @(posedge clk) begin
        if (!rst_n)           freq_o <= '0;
        else if (end_short)   freq_o <= {1'b0, sr_i[FREQ_W-2:0]};
        else if (end_mid)     freq_o <= sr_i[FREQ_W-1:0];
        else if (freq_mid_ld) freq_o <= sr_i[FREQ_W-1:0];
    end

    // Control group: full load from long words, ratio A from short/mid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '{cp: 1'b1, test: 3'b001, rsa: 1'b0, rsb: rsb_init_i, os: 1'b1};
        end else if (end_long) begin
            ctrl_o <= ctrl_t'(sr_i[CTRL_BITS-1:0]);
        end else if (end_short) begin
            ctrl_o.rsa <= 1'b1;
        end else if (end_mid) begin
            ctrl_o.rsa <= 1'b0;
        end
    end

    assert_band_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (band_o != $past(band_o)) |->
            $past(sck_rise_i && ce_lvl_i && cnt_i == CNT_W'(BAND_W)));

    assert_ctrl_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ({ctrl_o.cp, ctrl_o.test, ctrl_o.rsb, ctrl_o.os} !=
         $past({ctrl_o.cp, ctrl_o.test, ctrl_o.rsb, ctrl_o.os})) |->
            $past(ce_fall_i && cnt_i == CNT_W'(LEN_LONG)));

    assert_rsa_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o.rsa != $past(ctrl_o.rsa)) |->
            $past(ce_fall_i && (cnt_i == CNT_W'(LEN_SHORT) ||
                  cnt_i == CNT_W'(LEN_MID) || cnt_i == CNT_W'(LEN_LONG))));

    assert_freq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_o != $past(freq_o)) |->
            $past((ce_fall_i && (cnt_i == CNT_W'(LEN_SHORT) || cnt_i == CNT_W'(LEN_MID))) ||
                  (sck_rise_i && ce_lvl_i && cnt_i == CNT_W'(FREQ_AT))));

    assert_short_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_fall_i && cnt_i == CNT_W'(LEN_SHORT)) |-> (!freq_o[FREQ_W-1] && ctrl_o.rsa));
endmodule

// File: rtl/tw_word_receiver.sv
// Top of the three-wire tuning word receiver: edge finding, serial
// capture and length-decoded commit of band, divider and control fields.
// Assumes ce_i, sck_i and sdat_i are already synchronised to clk.
module tw_word_receiver
    import tw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_i,
    input  logic        sck_i,
    input  logic        sdat_i,
    input  logic        rsb_init_i,
    output logic [3:0]  band_o,
    output logic [14:0] freq_o,
    output logic        cp_o,
    output logic [2:0]  test_o,
    output logic        rsa_o,
    output logic        rsb_o,
    output logic        os_o
);
    localparam int CE_IX  = 1;
    localparam int SCK_IX = 0;

    logic [1:0]       rise, fall;
    logic [SR_W-1:0]  sr;
    logic [CNT_W-1:0] cnt;
    ctrl_t            ctrl;

    tw_edge_detect #(.N(2)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({ce_i, sck_i}),
        .rise_o (rise),
        .fall_o (fall)
    );

    tw_shift_count #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_lvl_i   (ce_i),
        .ce_rise_i  (rise[CE_IX]),
        .sck_fall_i (fall[SCK_IX]),
        .sdat_i     (sdat_i),
        .sr_o       (sr),
        .cnt_o      (cnt)
    );

    tw_commit_regs #(.SR_W(SR_W), .CNT_W(CNT_W)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsb_init_i (rsb_init_i),
        .ce_lvl_i   (ce_i),
        .ce_fall_i  (fall[CE_IX]),
        .sck_rise_i (rise[SCK_IX]),
        .cnt_i      (cnt),
        .sr_i       (sr),
        .band_o     (band_o),
        .freq_o     (freq_o),
        .ctrl_o     (ctrl)
    );

    // Break the control group out onto its ports.
    always_comb begin
        cp_o   = ctrl.cp;
        test_o = ctrl.test;
        rsa_o  = ctrl.rsa;
        rsb_o  = ctrl.rsb;
        os_o   = ctrl.os;
    end
endmodule

// File: tb/tw_word_receiver_tb.sv
module tw_word_receiver_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, sck = 1'b0, sdat = 1'b0, rsb_init = 1'b1;
    logic [3:0]  band;
    logic [14:0] freq;
    logic        cp, rsa, rsb, os;
    logic [2:0]  test;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench model of the outputs.
    logic [3:0]  m_band;
    logic [14:0] m_freq;
    logic        m_cp, m_rsa, m_rsb, m_os;
    logic [2:0]  m_test;
    logic [26:0] m_sr;
    int          m_cnt;

    always #5 clk = ~clk;

    tw_word_receiver u_dut (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .sck_i(sck), .sdat_i(sdat),
        .rsb_init_i(rsb_init), .band_o(band), .freq_o(freq), .cp_o(cp),
        .test_o(test), .rsa_o(rsa), .rsb_o(rsb), .os_o(os)
    );

    task automatic phase();
        repeat (3) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string freq_tag(input int len);
        if (len < 18)  return "R8";
        if (len == 18) return "R3";
        if (len == 19) return "R4";
        if (len > 31)  return "R10";
        if (len == 27) return "R5";
        return "R9";
    endfunction

    function automatic string ctrl_tag(input int len);
        if (len < 18)  return "R8";
        if (len == 18 || len == 19) return "R7";
        if (len > 31)  return "R10";
        if (len == 27) return "R6";
        return "R9";
    endfunction

    task automatic check_all(input string ft, input string ct);
        check("R2", "band", 32'(band), 32'(m_band));
        check(ft, "freq", 32'(freq), 32'(m_freq));
        check(ct, "cp", 32'(cp), 32'(m_cp));
        check(ct, "test", 32'(test), 32'(m_test));
        check(ct, "rsb", 32'(rsb), 32'(m_rsb));
        check(ct, "os", 32'(os), 32'(m_os));
        check(ft == "R3" || ft == "R4" ? ft : ct, "rsa", 32'(rsa), 32'(m_rsa));
    endtask

    task automatic do_reset(input logic strap);
        rsb_init = strap;
        rst_n = 1'b0;
        ce = 0; sck = 0; sdat = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_band = 0; m_freq = 0; m_cp = 1; m_test = 3'b001;
        m_rsa = 0; m_rsb = strap; m_os = 1;
        check_all("R11", "R11");
    endtask

    // Send a word; first bit is w[len-1]. Data is inverted while clock is high
    // and corrected before the falling edge (R1: only the falling edge samples).
    task automatic send_word(input int len, input logic [39:0] w);
        ce = 1; phase();
        m_cnt = 0;
        for (int i = 0; i < len; i++) begin
            logic b;
            b = w[len-1-i];
            sdat = ~b; sck = 1; phase();
            if (m_cnt == 4) begin
                m_band = m_sr[3:0];
                check("R2", "band mid-word", 32'(band), 32'(m_band));
            end
            if (m_cnt == 19) begin
                m_freq = m_sr[14:0];
                check("R5", "freq mid-word", 32'(freq), 32'(m_freq));
            end
            sdat = b; phase();
            sck = 0; phase();
            m_sr = {m_sr[25:0], b};
            if (m_cnt < 31) m_cnt++;
        end
        ce = 0; phase();
        if (m_cnt == 18) begin
            m_freq = {1'b0, m_sr[13:0]}; m_rsa = 1;
        end else if (m_cnt == 19) begin
            m_freq = m_sr[14:0]; m_rsa = 0;
        end else if (m_cnt == 27) begin
            {m_cp, m_test, m_rsa, m_rsb, m_os} = m_sr[6:0];
        end
        check_all(freq_tag(len), ctrl_tag(len));
    endtask

    // Shift-clock and data activity with enable low (R1).
    task automatic idle_noise();
        ce = 0;
        for (int i = 0; i < 12; i++) begin
            sdat = 1'($urandom); sck = 1; phase();
            sck = 0; phase();
        end
        check("R1", "band idle", 32'(band), 32'(m_band));
        check("R1", "freq idle", 32'(freq), 32'(m_freq));
        check("R1", "ctrl idle", 32'({cp, test, rsa, rsb, os}),
              32'({m_cp, m_test, m_rsa, m_rsb, m_os}));
    endtask

    initial begin
        void'($urandom(32'd24681));
        m_sr = '0;
        do_reset(1'b1);
        // Directed corner cases.
        send_word(18, 40'h0_0002_3200);      // band 1000, 14-bit divider
        send_word(19, 40'h0_0002_5140);      // full divider, rsa 0
        send_word(27, 40'h0_002E_A622 | 40'h88); // long word with control
        send_word(27, 40'h0_07FF_FFFF);      // all ones, marker included
        send_word(18, 40'h0_0003_ABCD);      // 18 keeps control
        send_word(10, 40'h0_0000_02A5);      // short: band only
        send_word(3, 40'h0_0000_0005);       // shorter than band field
        send_word(22, 40'h0_0035_A5A5);      // odd length: mid-word divider only
        send_word(40, 40'hA5_5AC3_3C96);     // over-long, count saturates
        send_word(19, 40'h0_0006_1234);      // decoded after saturation
        idle_noise();
        send_word(0, 40'h0);
        do_reset(1'b0);
        send_word(19, 40'h0_0004_6D60);
        // Random words.
        for (int n = 0; n < 60; n++) begin
            int sel, len;
            logic [39:0] w;
            sel = int'($urandom % 4);
            w = {8'($urandom), 32'($urandom)};
            case (sel)
                0: len = 18;
                1: len = 19;
                2: len = 27;
                default: len = int'($urandom % 36);
            endcase
            send_word(len, w);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule